// File: doc/BRIEF.md
# Descriptor-Chained SPI Master Sequencer

This block is a SPI master that carries out a whole transaction on its own, once a host has stored a list of command words in a small table of sixteen entries. Each entry gives a lane count, whether bytes go out, whether bytes come in, a unit size and a unit count, the index of the entry that follows, a flag that ends the list and a flag that releases chip select when the list ends. A start command always begins at entry 0. The block then steps through the list, generating SPI mode-0 clocks at a programmable rate and driving or releasing up to four IO lanes.

Outgoing bytes arrive through a valid/ready stream into a transmit FIFO; a byte is accepted on any cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the FIFO is full. Incoming bytes leave through a valid/ready stream from a receive FIFO; once `rx_valid` is high, `rx_valid` and `rx_data` hold until the cycle `rx_ready` is high. The SPI side does not drop data when the host falls behind. Instead, SCLK pauses between bytes until the starved or full FIFO recovers. Two sticky status flags report list completion and programming errors. A host clears either flag by writing 1 to its clear bit.

Top module: `spi_desc_seq`

## Requirements
- R1: An entry is the 32-bit word {5'b0, close[26], last[25], next[24:21], units[20:6], unit_size[5:4], rx_en[3], tx_en[2], lanes[1:0]}. A start runs entry 0 first and then the entry named by `next`. The list ends after the entry whose `last` bit is 1.
- R2: Lane code 0 (or 3) gives single lane, code 1 gives two lanes and code 2 gives four lanes. A byte takes 8, 4 or 2 SCLK pulses and is sent MSB first. Single lane sends on io[0] and receives on io[1]. Two lanes use io[1:0] and four lanes use io[3:0], with the higher lane carrying the earlier bit.
- R3: Unit size code 0 is 1 byte, code 1 is 4 bytes and code 2 is 16 bytes. An entry moves units × unit size bytes.
- R4: When the final entry has `close`=1, `cs_n` returns high after that entry. Otherwise `cs_n` stays low after completion until a stop command.
- R5: `sts_done` rises only when the final entry completes, never after an earlier entry. It stays set until `sts_clr[0]` is written with 1.
- R6: An entry with both tx_en and rx_en at 0 still produces its clocks, with every IO output enable low.
- R7: In single-lane mode with tx_en=0 and rx_en=1, io[0] is driven with 1.
- R8: With tx_en=1, SCLK pauses before a byte while the TX FIFO is empty. With rx_en=1, SCLK pauses while the RX FIFO (RX_DEPTH bytes) is full. No byte is lost in either case.
- R9: `cmd_stop` ends the list at once. On the next cycle `cs_n` is 1 and `sclk` is 0, and while `cs_n` is 1 all IO output enables are 0.
- R10: `cmd_clr_fifo` empties both FIFOs.
- R11: `sts_err` is set, and no new transfer begins, when a start arrives while a list is running or when an entry with units=0 is reached. In the second case `cs_n` goes high. `sts_clr[1]` written with 1 clears the flag.
- R12: Mode 0 applies: SCLK idles low, the input is sampled as SCLK rises and the output changes as SCLK falls. Each SCLK phase lasts clk_div+1 clock cycles.
- R13: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` stay unchanged on the next cycle, unless a FIFO clear is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the entry table |
| cfg_idx | input | 4 | Entry index to write |
| cfg_data | input | 32 | Entry word |
| cmd_start | input | 1 | Start pulse, begins at entry 0 |
| cmd_stop | input | 1 | Abort pulse |
| cmd_clr_fifo | input | 1 | Empty both FIFOs |
| sts_clr | input | 2 | Write-1-to-clear: bit 0 done, bit 1 error |
| clk_div | input | DIV_W | SCLK half period minus one, in clk cycles |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit FIFO can accept |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| sts_done | output | 1 | Sticky list-complete flag |
| sts_err | output | 1 | Sticky programming-error flag |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench uses single-lane writes to check MSB-first bit order and pulse counts. It uses four-lane reads with 4-byte and 16-byte units to check lane packing and unit scaling. A mixed three-entry list (single write, two-lane dummy, two-lane read) with non-adjacent indices shows that the `next` links are followed and that done does not rise early. Starving the TX FIFO and leaving the RX FIFO undrained show that SCLK pauses without losing bytes. A zero-count entry, a second start during a running list, a stop and a FIFO clear each check their own rule.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int DESC_NUM   = 16;
  localparam int DESC_IDX_W = 4;
  localparam int UNIT_W     = 15;
  localparam int LEFT_W     = UNIT_W + 4;

  typedef struct packed {
    logic [4:0]            rsvd;
    logic                  close;
    logic                  last;
    logic [DESC_IDX_W-1:0] nxt;
    logic [UNIT_W-1:0]     units;
    logic [1:0]            usz;
    logic                  rx_en;
    logic                  tx_en;
    logic [1:0]            lanes;
  } desc_t;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} seq_state_e;

  localparam logic [1:0] LANE_X2 = 2'd1;
  localparam logic [1:0] LANE_X4 = 2'd2;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST_SLOT) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST_SLOT) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [1:0]       lanes,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [3:0]       io_in,
  output logic             sclk,
  output logic             active,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic [3:0]       tx_bits
);
  logic [DIV_W-1:0] dcnt_q;
  logic [2:0]       ccnt_q;
  logic [7:0]       sh_tx_q, sh_rx_q;
  logic [1:0]       ln_q;
  logic [7:0]       rx_next, tx_next;
  logic [2:0]       ccnt_init;

  always_comb begin
    case (ln_q)
      LANE_X2: begin rx_next = {sh_rx_q[5:0], io_in[1:0]}; tx_next = sh_tx_q << 2; end
      LANE_X4: begin rx_next = {sh_rx_q[3:0], io_in};      tx_next = sh_tx_q << 4; end
      default: begin rx_next = {sh_rx_q[6:0], io_in[1]};   tx_next = sh_tx_q << 1; end
    endcase
    case (lanes)
      LANE_X2: ccnt_init = 3'd3;
      LANE_X4: ccnt_init = 3'd1;
      default: ccnt_init = 3'd7;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk    <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
      dcnt_q  <= '0;
      ccnt_q  <= '0;
      sh_tx_q <= '0;
      sh_rx_q <= '0;
      ln_q    <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sclk   <= 1'b0;
      end else if (start && !active) begin
        active  <= 1'b1;
        sclk    <= 1'b0;
        dcnt_q  <= '0;
        ln_q    <= lanes;
        sh_tx_q <= tx_byte;
        ccnt_q  <= ccnt_init;
      end else if (active) begin
        if (dcnt_q == clk_div) begin
          dcnt_q <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            sh_rx_q <= rx_next;
          end else begin
            sclk <= 1'b0;
            if (ccnt_q == 3'd0) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              ccnt_q  <= ccnt_q - 3'd1;
              sh_tx_q <= tx_next;
            end
          end
        end else begin
          dcnt_q <= dcnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign rx_byte = sh_rx_q;
  assign tx_bits = sh_tx_q[7:4];
endmodule

// File: rtl/spi_desc_seq.sv
module spi_desc_seq
  import spi_seq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int DIV_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [DESC_IDX_W-1:0] cfg_idx,
  input  logic [31:0]           cfg_data,
  input  logic                  cmd_start,
  input  logic                  cmd_stop,
  input  logic                  cmd_clr_fifo,
  input  logic [1:0]            sts_clr,
  input  logic [DIV_W-1:0]      clk_div,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [7:0]            tx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [7:0]            rx_data,
  output logic                  sts_done,
  output logic                  sts_err,
  output logic                  sclk,
  output logic                  cs_n,
  output logic [3:0]            io_out,
  output logic [3:0]            io_oe,
  input  logic [3:0]            io_in
);
  desc_t                 dtab [DESC_NUM];
  desc_t                 ld, cur_q;
  seq_state_e            state_q;
  logic [DESC_IDX_W-1:0] idx_q;
  logic [LEFT_W-1:0]     left_q, ld_bytes;
  logic                  tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]            tx_head, eng_rx;
  logic [3:0]            eng_bits;
  logic                  eng_active, eng_done, start_byte, tx_pop, rx_push;
  logic                  set_done, set_err, running;

  function automatic logic [2:0] unit_shift(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_NUM; i++) dtab[i] <= '0;
    end else if (cfg_we) begin
      dtab[cfg_idx] <= desc_t'(cfg_data);
    end
  end

  assign ld       = dtab[idx_q];
  assign ld_bytes = LEFT_W'(ld.units) << unit_shift(ld.usz);
  assign running  = (state_q != S_IDLE);

  spi_byte_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(cmd_clr_fifo),
    .push(tx_valid && tx_ready), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_byte_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(cmd_clr_fifo),
    .push(rx_push), .wdata(eng_rx),
    .pop(rx_valid && rx_ready), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
  );

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;

  assign start_byte = (state_q == S_RUN) && !cmd_stop && !eng_active && !eng_done &&
                      (left_q != '0) && (!cur_q.tx_en || !tx_empty) &&
                      (!cur_q.rx_en || !rx_full);
  assign tx_pop  = start_byte && cur_q.tx_en;
  assign rx_push = (state_q == S_RUN) && eng_done && cur_q.rx_en;

  spi_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(cmd_stop), .start(start_byte),
    .lanes(cur_q.lanes), .tx_byte(cur_q.tx_en ? tx_head : 8'h00),
    .clk_div(clk_div), .io_in(io_in), .sclk(sclk), .active(eng_active),
    .done(eng_done), .rx_byte(eng_rx), .tx_bits(eng_bits)
  );

  assign set_err  = (cmd_start && running) ||
                    (state_q == S_LOAD && ld.units == '0 && !cmd_stop);
  assign set_done = (state_q == S_RUN) && !cmd_stop && !eng_done && !eng_active &&
                    (left_q == '0) && cur_q.last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      left_q  <= '0;
      cs_n    <= 1'b1;
    end else if (cmd_stop) begin
      state_q <= S_IDLE;
      cs_n    <= 1'b1;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (cmd_start) begin
            idx_q   <= '0;
            state_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          cur_q <= ld;
          if (ld.units == '0) begin
            cs_n    <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            left_q  <= ld_bytes;
            cs_n    <= 1'b0;
            state_q <= S_RUN;
          end
        end
        S_RUN: begin
          if (eng_done) begin
            left_q <= left_q - 1'b1;
          end else if (!eng_active && left_q == '0) begin
            if (cur_q.last) begin
              if (cur_q.close) cs_n <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              idx_q   <= cur_q.nxt;
              state_q <= S_LOAD;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_done <= 1'b0;
      sts_err  <= 1'b0;
    end else begin
      sts_done <= set_done | (sts_done & ~sts_clr[0]);
      sts_err  <= set_err  | (sts_err  & ~sts_clr[1]);
    end
  end

  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0000;
    if (state_q == S_RUN) begin
      case (cur_q.lanes)
        LANE_X2: begin
          io_out = {2'b00, eng_bits[3:2]};
          io_oe  = cur_q.tx_en ? 4'b0011 : 4'b0000;
        end
        LANE_X4: begin
          io_out = eng_bits;
          io_oe  = cur_q.tx_en ? 4'b1111 : 4'b0000;
        end
        default: begin
          io_out = {3'b000, cur_q.tx_en ? eng_bits[3] : 1'b1};
          io_oe  = {3'b000, cur_q.tx_en | cur_q.rx_en};
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_desc_seq_chk.sv
module spi_desc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       cmd_stop,
  input logic       cmd_clr_fifo,
  input logic [1:0] sts_clr,
  input logic       sts_done,
  input logic       sts_err,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       busy
);
  p_sclk_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_quiet_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (cs_n && !sclk));

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_done && !sts_clr[0]) |=> sts_done);

  p_busy_start_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && busy) |=> sts_err);

  p_rx_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !cmd_clr_fifo) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_desc_seq spi_desc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .cmd_clr_fifo(cmd_clr_fifo), .sts_clr(sts_clr), .sts_done(sts_done),
  .sts_err(sts_err), .cs_n(cs_n), .sclk(sclk), .io_oe(io_oe),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .busy(running)
);

// File: tb/spi_desc_seq_tb.sv
module spi_desc_seq_tb;
  localparam int RXD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [3:0] cfg_idx = 0; logic [31:0] cfg_data = 0;
  logic cmd_start = 0, cmd_stop = 0, cmd_clr_fifo = 0;
  logic [1:0] sts_clr = 0; logic [7:0] clk_div = 8'd1;
  logic tx_valid = 0, tx_ready; logic [7:0] tx_data = 0;
  logic rx_valid, rx_ready = 0; logic [7:0] rx_data;
  logic sts_done, sts_err, sclk, cs_n;
  logic [3:0] io_out, io_oe, io_in;

  int n_chk = 0, n_fail = 0;
  int clk_cnt = 0, dummy_bad = 0, ones_bad = 0, hi_run = 0, last_hi = 0;
  logic [3:0] oe_or = 0;
  logic [63:0] cap0 = 0;
  logic [127:0] sreg = 0;
  int tb_lanes = 0;

  always #2 clk = ~clk;

  spi_desc_seq #(.TX_DEPTH(8), .RX_DEPTH(RXD), .DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_clr_fifo(cmd_clr_fifo),
    .sts_clr(sts_clr), .clk_div(clk_div), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sts_done(sts_done), .sts_err(sts_err), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  assign io_in = (tb_lanes == 0) ? {2'b00, sreg[127], 1'b0} :
                 (tb_lanes == 1) ? {2'b00, sreg[127:126]} : sreg[127:124];

  always @(posedge sclk) begin
    clk_cnt = clk_cnt + 1;
    cap0 = {cap0[62:0], io_out[0]};
    oe_or = oe_or | io_oe;
    if (!(io_out[0] && io_oe[0])) ones_bad = ones_bad + 1;
    if (clk_cnt >= 9 && clk_cnt <= 16 && io_oe != 4'b0000) dummy_bad = dummy_bad + 1;
  end

  always @(negedge sclk)
    sreg = sreg << ((tb_lanes == 0) ? 1 : (tb_lanes == 1) ? 2 : 4);

  always @(negedge clk) begin
    if (sclk) hi_run = hi_run + 1;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  function automatic logic [31:0] mk(input int lanes, input bit tx, input bit rx,
                                     input int usz, input int cnt, input int nxt,
                                     input bit last, input bit close);
    return {5'b0, close, last, 4'(nxt), 15'(cnt), 2'(usz), rx, tx, 2'(lanes)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_desc(input int i, input logic [31:0] d);
    cfg_idx = 4'(i); cfg_data = d; cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_data = b; tx_valid = 1; @(negedge clk); tx_valid = 0;
  endtask

  task automatic pulse_start(); cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
  task automatic pulse_stop();  cmd_stop  = 1; @(negedge clk); cmd_stop  = 0; endtask

  task automatic clear_all();
    sts_clr = 2'b11; @(negedge clk); sts_clr = 0;
    clk_cnt = 0; dummy_bad = 0; ones_bad = 0; oe_or = 0; cap0 = 0;
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 5000 && !sts_done; i++) @(negedge clk);
    chk(sts_done === 1'b1, tag, sts_done, 1);
  endtask

  task automatic read_rx(input logic [7:0] exp, input string tag);
    for (int i = 0; i < 2000 && !rx_valid; i++) @(negedge clk);
    chk(rx_valid === 1'b1 && rx_data === exp, tag, rx_data, exp);
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1 && sclk === 1'b0, "R12 reset idle", {cs_n, sclk}, 2'b10);
    chk(sts_done === 1'b0 && sts_err === 1'b0, "R5 reset status", {sts_done, sts_err}, 0);
    chk(io_oe === 4'b0000 && tx_ready === 1'b1 && rx_valid === 1'b0, "R9 reset io", io_oe, 0);
  endtask

  task automatic t_single_tx();
    clear_all(); tb_lanes = 0;
    put_desc(0, mk(0, 1, 0, 0, 2, 0, 1, 1));
    push_tx(8'hA5); push_tx(8'h3C);
    pulse_start(); wait_done("R1 single tx done");
    chk(clk_cnt == 16, "R2 single clocks", clk_cnt, 16);
    chk(cap0[15:0] == 16'hA53C, "R2 msb first", cap0[15:0], 16'hA53C);
    chk(cs_n === 1'b1, "R4 close", cs_n, 1);
    chk(last_hi == 2, "R12 half period", last_hi, 2);
    sts_clr = 2'b01; @(negedge clk); sts_clr = 0;
    chk(sts_done === 1'b0, "R5 w1c done", sts_done, 0);
  endtask

  task automatic t_quad_rx();
    clear_all(); tb_lanes = 2; sreg = {32'h12345678, 96'h0};
    put_desc(0, mk(2, 0, 1, 1, 1, 0, 1, 1));
    pulse_start(); wait_done("R3 quad rx done");
    chk(clk_cnt == 8, "R3 4-byte unit clocks", clk_cnt, 8);
    chk(oe_or == 4'b0000, "R2 quad rx no drive", oe_or, 0);
    read_rx(8'h12, "R2 quad byte0"); read_rx(8'h34, "R2 quad byte1");
    read_rx(8'h56, "R2 quad byte2"); read_rx(8'h78, "R2 quad byte3");
  endtask

  task automatic t_chain();
    clear_all(); tb_lanes = 1; sreg = 0; sreg[95:88] = 8'hC7;
    put_desc(0, mk(0, 1, 0, 0, 1, 3, 0, 0));
    put_desc(3, mk(1, 0, 0, 0, 2, 5, 0, 0));
    put_desc(5, mk(1, 0, 1, 0, 1, 0, 1, 1));
    push_tx(8'h96);
    pulse_start();
    for (int i = 0; i < 2000 && clk_cnt < 10; i++) @(negedge clk);
    chk(sts_done === 1'b0, "R5 not done mid chain", sts_done, 0);
    wait_done("R1 chain done");
    chk(clk_cnt == 20, "R1 chain clocks", clk_cnt, 20);
    chk(dummy_bad == 0, "R6 dummy tristate", dummy_bad, 0);
    chk(cap0[19:12] == 8'h96, "R1 chain tx byte", cap0[19:12], 8'h96);
    read_rx(8'hC7, "R2 dual rx byte");
  endtask

  task automatic t_no_close();
    clear_all(); tb_lanes = 0; sreg = {8'hB2, 120'h0};
    put_desc(0, mk(0, 0, 1, 0, 1, 0, 1, 0));
    pulse_start(); wait_done("R4 no-close done");
    chk(cs_n === 1'b0, "R4 cs held", cs_n, 0);
    chk(ones_bad == 0, "R7 io0 ones", ones_bad, 0);
    read_rx(8'hB2, "R2 single rx byte");
    pulse_stop();
    chk(cs_n === 1'b1 && sclk === 1'b0, "R9 stop release", {cs_n, sclk}, 2'b10);
  endtask

  task automatic t_zero_count();
    clear_all();
    put_desc(0, mk(0, 1, 0, 0, 0, 0, 1, 1));
    pulse_start(); cyc(20);
    chk(sts_err === 1'b1, "R11 zero count err", sts_err, 1);
    chk(clk_cnt == 0 && cs_n === 1'b1, "R11 no transfer", clk_cnt, 0);
    chk(sts_done === 1'b0, "R5 no done on err", sts_done, 0);
    sts_clr = 2'b10; @(negedge clk); sts_clr = 0;
    chk(sts_err === 1'b0, "R11 w1c err", sts_err, 0);
  endtask

  task automatic t_tx_stall();
    clear_all(); tb_lanes = 0;
    put_desc(0, mk(0, 1, 0, 0, 2, 0, 1, 1));
    push_tx(8'h81);
    pulse_start();
    for (int i = 0; i < 2000 && clk_cnt < 8; i++) @(negedge clk);
    cyc(100);
    chk(clk_cnt == 8 && cs_n === 1'b0, "R8 tx stall", clk_cnt, 8);
    pulse_start();
    chk(sts_err === 1'b1, "R11 start while busy", sts_err, 1);
    push_tx(8'h7E);
    wait_done("R8 tx resume done");
    chk(clk_cnt == 16, "R8 tx total clocks", clk_cnt, 16);
    chk(cap0[15:0] == 16'h817E, "R8 tx data intact", cap0[15:0], 16'h817E);
  endtask

  task automatic t_rx_stall();
    logic [127:0] pat;
    clear_all(); tb_lanes = 2;
    pat = 128'h0123456789ABCDEF_FEDCBA9876543210; sreg = pat;
    put_desc(0, mk(2, 0, 1, 2, 1, 0, 1, 1));
    pulse_start(); cyc(300);
    chk(clk_cnt == 2 * RXD, "R8 rx stall clocks", clk_cnt, 2 * RXD);
    chk(sts_done === 1'b0, "R8 rx stall not done", sts_done, 0);
    for (int i = 0; i < 16; i++) read_rx(pat[127 - 8*i -: 8], "R8 rx byte no loss");
    wait_done("R3 16-byte unit done");
    chk(clk_cnt == 32, "R3 16-byte unit clocks", clk_cnt, 32);
  endtask

  task automatic t_clear();
    clear_all(); tb_lanes = 0; sreg = {8'h5A, 120'h0};
    put_desc(0, mk(0, 0, 1, 0, 1, 0, 1, 1));
    pulse_start(); wait_done("R10 setup rx");
    chk(rx_valid === 1'b1, "R10 rx pending", rx_valid, 1);
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    cmd_clr_fifo = 1; @(negedge clk); cmd_clr_fifo = 0;
    chk(rx_valid === 1'b0, "R10 rx emptied", rx_valid, 0);
    clear_all();
    put_desc(0, mk(0, 1, 0, 0, 1, 0, 1, 1));
    pulse_start(); cyc(100);
    chk(clk_cnt == 0, "R10 tx emptied", clk_cnt, 0);
    pulse_stop();
    chk(cs_n === 1'b1, "R9 stop mid stall", cs_n, 1);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog R1: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_single_tx();
    t_quad_rx();
    t_chain();
    t_no_close();
    t_zero_count();
    t_tx_stall();
    t_rx_stall();
    t_clear();
    cyc(5);
    summary();
    $finish;
  end
endmodule